// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block collects level-sensitive interrupt requests from up to 64 peripheral sources and steers each one onto one of nine prioritized core interrupt lines (line 0 is the highest-priority general-purpose line, line 8 the lowest). Every source owns a 4-bit selector that names its target line. It also has a per-source enable bit and a per-source wakeup-enable bit. Each core line is the OR of all enabled, pending sources that select it. A separate wakeup output fires for any pending source whose wakeup path is enabled, whether or not the source is enabled for interrupts.

Software reaches the block through a plain register port with write strobe, read strobe, word address and 32-bit data. Incoming request levels pass through a two-flop synchronizer, and the synchronized levels are the pending status. Status is cleared at the peripheral, never through this block. The router contains no arbitration. It presents the nine-bit request vector to the core's event arbiter.

Top module: `irq_router`

## Requirements
- R1: After reset, the selector of source i reads min(i/8, 8), all enable bits and wakeup-enable bits read 0, and `irq_line` and `wake_req` are 0.
- R2: The status word at address 10 (sources 0–31) and address 11 (sources 32–63) reads the `irq_in` levels two clock edges after they change. Writes to those addresses change nothing.
- R3: `irq_line[k]` is 1 exactly three clock edges after a source with selector k, enable bit 1 and request high is presented. For a constant request it is 0 after two edges.
- R4: A source whose enable bit is 0 drives no line. Clearing the bit drops a line that only that source held.
- R5: Selector values 9 to 15 are stored and read back as written but drive no line.
- R6: A line stays asserted while at least one enabled, pending source selects it, so several sources may share one line.
- R7: `wake_req` is 1 when any pending source has its wakeup-enable bit set, independent of its enable bit. It has the same latency as a line.
- R8: Selector words sit at addresses 0–7, with source 8w+j in bits 4j+3..4j of word w. Enable words are at 8–9 and wakeup-enable words at 12–13, with source 32w+b at bit b. Reads return data on the edge after the `rd_en` cycle. `rdata` holds its value when no read takes place. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq_in | input | 64 | Peripheral request levels |
| irq_line | output | 9 | Core interrupt line requests |
| wake_req | output | 1 | Wakeup request |

## Verification
A register write that changes an enable bit, selector or wakeup-enable bit can land in the same cycle as a change in a source's request level. The bench provokes this by driving both on the same clock cycle, either raising a request while its enable bit is being cleared or dropping a request while its selector is being rewritten. Once the latency has passed, it judges the lines and the wakeup output against a model that applies both changes. The line must never show the new request combined with the old configuration once the block has settled.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_LINES = 9;
  localparam int SEL_W     = 4;
  localparam int DATA_W    = 32;
  localparam int SEL_PER_WORD = DATA_W / SEL_W;

  function automatic logic [SEL_W-1:0] reset_sel(input int src);
    int v;
    v = src / SEL_PER_WORD;
    if (v > NUM_LINES - 1) v = NUM_LINES - 1;
    return SEL_W'(v);
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  input  logic [NUM_SRC-1:0]       stat_vec,
  output logic [NUM_SRC-1:0]       mask_vec,
  output logic [NUM_SRC-1:0]       wake_vec,
  output logic [NUM_SRC*SEL_W-1:0] sel_flat
);
  localparam int SEL_WORDS = NUM_SRC / SEL_PER_WORD;
  localparam int BIT_WORDS = NUM_SRC / DATA_W;
  localparam int MASK_BASE = SEL_WORDS;
  localparam int STAT_BASE = MASK_BASE + BIT_WORDS;
  localparam int WAKE_BASE = STAT_BASE + BIT_WORDS;

  logic [NUM_SRC*SEL_W-1:0] sel_q;
  logic [NUM_SRC-1:0]       mask_q;
  logic [NUM_SRC-1:0]       wake_q;
  logic [DATA_W-1:0]        rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) sel_q[i*SEL_W +: SEL_W] <= reset_sel(i);
      mask_q <= '0;
      wake_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < SEL_WORDS; w++)
        if (addr == ADDR_W'(w)) sel_q[w*DATA_W +: DATA_W] <= wdata;
      for (int w = 0; w < BIT_WORDS; w++) begin
        if (addr == ADDR_W'(MASK_BASE + w)) mask_q[w*DATA_W +: DATA_W] <= wdata;
        if (addr == ADDR_W'(WAKE_BASE + w)) wake_q[w*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < SEL_WORDS; w++)
      if (addr == ADDR_W'(w)) rd_word = sel_q[w*DATA_W +: DATA_W];
    for (int w = 0; w < BIT_WORDS; w++) begin
      if (addr == ADDR_W'(MASK_BASE + w)) rd_word = mask_q[w*DATA_W +: DATA_W];
      if (addr == ADDR_W'(STAT_BASE + w)) rd_word = stat_vec[w*DATA_W +: DATA_W];
      if (addr == ADDR_W'(WAKE_BASE + w)) rd_word = wake_q[w*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign mask_vec = mask_q;
  assign wake_vec = wake_q;
  assign sel_flat = sel_q;
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       stat_vec,
  input  logic [NUM_SRC-1:0]       mask_vec,
  input  logic [NUM_SRC-1:0]       wake_vec,
  input  logic [NUM_SRC*SEL_W-1:0] sel_flat,
  output logic [NUM_LINES-1:0]     line_q,
  output logic                     wake_q
);
  logic [NUM_LINES-1:0] line_d;

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic [NUM_SRC-1:0] hit;
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[i] = stat_vec[i] & mask_vec[i] &
                      (sel_flat[i*SEL_W +: SEL_W] == SEL_W'(k));
    end
    assign line_d[k] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      wake_q <= 1'b0;
    end else begin
      line_q <= line_d;
      wake_q <= |(stat_vec & wake_vec);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic [NUM_LINES-1:0] irq_line,
  output logic                 wake_req
);
  logic [NUM_SRC-1:0]       stat_vec;
  logic [NUM_SRC-1:0]       mask_vec;
  logic [NUM_SRC-1:0]       wake_vec;
  logic [NUM_SRC*SEL_W-1:0] sel_flat;

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(stat_vec)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .stat_vec(stat_vec), .mask_vec(mask_vec),
    .wake_vec(wake_vec), .sel_flat(sel_flat)
  );

  irq_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk(clk), .rst_n(rst_n), .stat_vec(stat_vec), .mask_vec(mask_vec),
    .wake_vec(wake_vec), .sel_flat(sel_flat), .line_q(irq_line), .wake_q(wake_req)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic [31:0]        rdata,
  input logic [8:0]         irq_line,
  input logic               wake_req,
  input logic [NUM_SRC-1:0] stat_vec,
  input logic [NUM_SRC-1:0] mask_vec,
  input logic [NUM_SRC-1:0] wake_vec
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_line == '0 && !wake_req));

  p_line_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != '0) |-> $past(|(stat_vec & mask_vec)));

  p_wake_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(|(stat_vec & wake_vec)));

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rdata(rdata), .irq_line(irq_line),
  .wake_req(wake_req), .stat_vec(stat_vec), .mask_vec(mask_vec), .wake_vec(wake_vec)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] irq_in = '0;
  logic [8:0]  irq_line;
  logic        wake_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0]   m_sel [N];
  logic [N-1:0] m_mask = '0;
  logic [N-1:0] m_wake = '0;

  always #2.5 clk = ~clk;

  irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .irq_line(irq_line),
    .wake_req(wake_req)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
    if (a < 5'd8)
      for (int j = 0; j < 8; j++) m_sel[a*8+j] = d[j*4 +: 4];
    else if (a == 5'd8)  m_mask[31:0]  = d;
    else if (a == 5'd9)  m_mask[63:32] = d;
    else if (a == 5'd12) m_wake[31:0]  = d;
    else if (a == 5'd13) m_wake[63:32] = d;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic [8:0] exp_lines(input logic [N-1:0] lv);
    logic [8:0] r = '0;
    for (int i = 0; i < N; i++)
      if (lv[i] && m_mask[i] && m_sel[i] < 4'd9) r[m_sel[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_wake(input logic [N-1:0] lv);
    return |(lv & m_wake);
  endfunction

  task automatic settle_check(input string req);
    repeat (4) @(negedge clk);
    chk(irq_line == exp_lines(irq_in), req, 64'(irq_line), 64'(exp_lines(irq_in)));
    chk(wake_req == exp_wake(irq_in), req, 64'(wake_req), 64'(exp_wake(irq_in)));
  endtask

  initial begin
    logic [31:0] d;
    int sel_v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      sel_v = i / 8;
      m_sel[i] = 4'((sel_v > 8) ? 8 : sel_v);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(irq_line == '0 && !wake_req, "R1 outputs", {54'd0, wake_req, irq_line}, 64'd0);
    for (int w = 0; w < 8; w++) begin
      rd(5'(w), d);
      chk(d == {8{4'(w)}}, "R1 selector defaults", 64'(d), 64'({8{4'(w)}}));
    end
    rd(5'd8, d);  chk(d == 32'd0, "R1 enable word", 64'(d), 64'd0);
    rd(5'd13, d); chk(d == 32'd0, "R1 wake word", 64'(d), 64'd0);

    // R3 latency: source 3, selector 0
    wr(5'd8, 32'h0000_0008);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq_line == 9'd0, "R3 not yet after two edges", 64'(irq_line), 64'd0);
    @(negedge clk);
    chk(irq_line == 9'd1, "R3 asserted after three edges", 64'(irq_line), 64'd1);

    // R2 status read and write ignored
    rd(5'd10, d); chk(d == irq_in[31:0], "R2 status read", 64'(d), 64'(irq_in[31:0]));
    wr(5'd10, 32'hFFFF_FFFF);
    rd(5'd10, d); chk(d == irq_in[31:0], "R2 status write ignored", 64'(d), 64'(irq_in[31:0]));

    // R6 shared line: sources 3 and 5 on selector 0
    wr(5'd8, 32'h0000_0028);
    irq_in[5] = 1'b1;
    settle_check("R6 two sources");
    irq_in[3] = 1'b0;
    settle_check("R6 one remaining");
    chk(irq_line[0] == 1'b1, "R6 line held", 64'(irq_line), 64'd1);

    // R4 clearing enable drops the line
    wr(5'd8, 32'h0000_0000);
    settle_check("R4 disabled");
    chk(irq_line == 9'd0, "R4 no line", 64'(irq_line), 64'd0);

    // R5 out-of-range selector
    wr(5'd0, 32'h0000_C000);
    wr(5'd8, 32'h0000_0008);
    irq_in = '0; irq_in[3] = 1'b1;
    settle_check("R5 selector 12");
    chk(irq_line == 9'd0, "R5 no line", 64'(irq_line), 64'd0);
    rd(5'd0, d); chk(d == 32'h0000_C000, "R5 readback", 64'(d), 64'h0000_C000);

    // R7 wakeup independent of enable
    wr(5'd8, 32'h0);
    wr(5'd12, 32'h0000_0001);
    irq_in[0] = 1'b1;
    settle_check("R7 wake");
    chk(wake_req == 1'b1 && irq_line == 9'd0, "R7 wake without line", {54'd0, wake_req, irq_line}, 64'h200);

    // R8 unmapped address and word placement
    rd(5'd20, d); chk(d == 32'd0, "R8 unmapped", 64'(d), 64'd0);
    wr(5'd7, 32'h8000_0000);
    wr(5'd9, 32'h8000_0000);
    irq_in = '0; irq_in[63] = 1'b1;
    settle_check("R8 source 63 selector 8");
    chk(irq_line == 9'h100, "R8 line 8", 64'(irq_line), 64'h100);

    // same-cycle: enable write coincides with request change
    @(negedge clk);
    wr_en = 1'b1; addr = 5'd9; wdata = 32'h0; irq_in[62] = 1'b1;
    @(negedge clk); wr_en = 1'b0; m_mask[63:32] = 32'h0;
    settle_check("R4 same-cycle enable clear");

    // random
    for (int it = 0; it < 150; it++) begin
      if (it % 10 == 0) begin
        for (int w = 0; w < 8; w++) wr(5'(w), $urandom);
        wr(5'd8, $urandom); wr(5'd9, $urandom);
        wr(5'd12, $urandom & $urandom); wr(5'd13, $urandom & $urandom);
      end
      @(negedge clk);
      irq_in = {$urandom, $urandom};
      if (it % 7 == 3) begin
        wr_en = 1'b1; addr = 5'd8; wdata = $urandom;
        @(negedge clk); wr_en = 1'b0; m_mask[31:0] = wdata;
      end
      settle_check("R3 R6 R7 random");
      if (it % 5 == 0) begin
        rd(5'd11, d);
        chk(d == irq_in[63:32], "R2 random status", 64'(d), 64'(irq_in[63:32]));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule